// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block watches CPU writes into a cartridge ROM window and recognises the standard unlock-and-command write sequences of a parallel NOR flash device. It does not hold the flash array. Instead it reports, one clock after the deciding write, what the attached storage model or controller must do. The possible outcomes are a byte program, a refused program on a byte that is not blank, an erase of one 128 KiB sector, or an erase of the whole chip. It also holds a level flag that selects the device's query (identification table) view in place of normal array reads.

Only the low 12 bits of the CPU address take part in the matching. The two unlock locations are 0xAAA and 0x555. The surrounding mapper also supplies the full bank-mapped address of each write and the byte currently stored at that address. The decoder uses them to compute the sector index and to decide whether a program may proceed. All decoding is gated by a flash-save enable, so a cartridge built from plain ROM ignores these writes entirely.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is active, and afterwards until a command is decoded, `cfi_mode` is 0 and every pulse output is 0. Asserting reset while query mode is active clears it.
- R2: A write of 0x98 to address 0xAAA as the first write of a sequence sets `cfi_mode` to 1 from the next cycle. Any other data value at 0xAAA, and 0x98 at 0x555, leave it at 0.
- R3: A write with data 0xF0, at any address and at any point of a sequence, clears `cfi_mode` and restarts the sequence. Query mode otherwise persists across other writes.
- R4: The writes AA@0xAAA, 55@0x555 and A0@0xAAA, followed by a fourth write of any data to any address, produce a one-cycle `prog_pulse`. When it fires, `op_addr` holds the fourth write's mapped address and `op_data` holds its data. The sequence then restarts.
- R5: If `cur_byte` is not 0xFF on that fourth write, `prog_refused` pulses for one cycle and `prog_pulse` stays 0.
- R6: The writes AA@0xAAA, 55@0x555, 80@0xAAA, AA@0xAAA and 55@0x555, followed by a sixth write of data 0x30, produce a one-cycle `sect_erase_pulse`. In that cycle `sector_idx` equals the sixth write's mapped address divided by 2^17.
- R7: The same five-write prefix followed by data 0x10 produces a one-cycle `chip_erase_pulse`. Any other sixth data value produces no erase pulse.
- R8: A write to any address other than 0xAAA or 0x555 restarts the sequence, so the writes that preceded it no longer count toward a command.
- R9: The sequence position saturates after 10 recorded writes. Any number of further unlock-address writes neither wraps it nor makes a later write count as the first write of a sequence.
- R10: When `save_en` is 0, writes are ignored: no pulse fires and `cfi_mode` keeps its value.
- R11: A pulse lasts exactly one cycle, and at most one of `prog_pulse`, `prog_refused`, `sect_erase_pulse` and `chip_erase_pulse` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| save_en | input | 1 | Enables command decoding (flash-backed cartridge) |
| wr_en | input | 1 | One-cycle CPU write strobe into the ROM window |
| wr_addr | input | 12 | Low 12 bits of the CPU write address |
| wr_data | input | 8 | CPU write data |
| map_addr | input | MAP_AW (25) | Full bank-mapped flash address of the write |
| cur_byte | input | 8 | Byte currently stored at `map_addr` |
| prog_pulse | output | 1 | Program the byte at `op_addr` with `op_data` |
| prog_refused | output | 1 | A program command hit a byte that is not blank |
| sect_erase_pulse | output | 1 | Erase the sector given by `sector_idx` |
| chip_erase_pulse | output | 1 | Erase the whole device |
| sector_idx | output | MAP_AW-SECTOR_LOG2 (8) | Sector number of the erase |
| op_addr | output | MAP_AW (25) | Mapped address of the last deciding write |
| op_data | output | 8 | Data of the last deciding write |
| cfi_mode | output | 1 | Query mode is active |

## Verification
On every cycle, assertions check that the outcome pulses are mutually exclusive and that none follows a cycle with no enabled write. They also check that a program never fires on a non-blank byte, that the sector index matches the mapped address, that 0xF0 always leaves query mode, that a first-position 0x98 at 0xAAA enters it, and that the sequence position never passes its limit. Whether whole sequences decode correctly can only be shown by the bench's scenarios. These cover sweeps of every sixth-write data value, every current-byte value and every first-write value, together with aborts by a foreign address or by 0xF0, saturation after a long run of unlock writes, and ignored writes with saving disabled.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [11:0] UNLOCK_HI = 12'hAAA;
  localparam logic [11:0] UNLOCK_LO = 12'h555;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] SEL_SECTOR = 8'h30;
  localparam logic [7:0] SEL_CHIP   = 8'h10;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_EXIT    = 8'hF0;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  typedef struct packed {
    logic unlock;     // address is one of the two unlock locations
    logic query;      // query-mode entry pattern
    logic leave;      // exit/reset data value
    logic prog_ok;    // write matches the program prefix at its position
    logic erase_ok;   // write matches the erase prefix at its position
    logic sel_sector; // erase selector: one sector
    logic sel_chip;   // erase selector: whole device
  } step_t;

endpackage

// File: rtl/flash_cmd_rst_sync.sv
module flash_cmd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic [11:0]      addr,
  input  logic [7:0]       data,
  input  logic [POS_W-1:0] pos,
  output step_t            step
);
  logic at_hi;
  logic at_lo;

  assign at_hi = (addr == UNLOCK_HI);
  assign at_lo = (addr == UNLOCK_LO);

  always_comb begin
    step            = '0;
    step.unlock     = at_hi | at_lo;
    step.query      = at_hi & (data == OP_QUERY);
    step.leave      = (data == OP_EXIT);
    step.sel_sector = (data == SEL_SECTOR);
    step.sel_chip   = (data == SEL_CHIP);

    // Program prefix: positions 0..2 must match, later positions are free.
    case (pos)
      POS_W'(0): step.prog_ok = at_hi & (data == KEY_FIRST);
      POS_W'(1): step.prog_ok = at_lo & (data == KEY_SECOND);
      POS_W'(2): step.prog_ok = at_hi & (data == OP_PROGRAM);
      default:   step.prog_ok = 1'b1;
    endcase

    // Erase prefix: positions 0..4 must match, later positions are free.
    case (pos)
      POS_W'(0): step.erase_ok = at_hi & (data == KEY_FIRST);
      POS_W'(1): step.erase_ok = at_lo & (data == KEY_SECOND);
      POS_W'(2): step.erase_ok = at_hi & (data == OP_ERASE);
      POS_W'(3): step.erase_ok = at_hi & (data == KEY_FIRST);
      POS_W'(4): step.erase_ok = at_lo & (data == KEY_SECOND);
      default:   step.erase_ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int HIST_DEPTH = 10,
  parameter int POS_W      = $clog2(HIST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  step_t            step,
  output logic [POS_W-1:0] pos,
  output logic             hit_prog,
  output logic             hit_sector,
  output logic             hit_chip,
  output logic             cfi_mode
);
  localparam logic [POS_W-1:0] POS_LIMIT = POS_W'(HIST_DEPTH);
  localparam logic [POS_W-1:0] POS_PROG  = POS_W'(3);
  localparam logic [POS_W-1:0] POS_ERASE = POS_W'(5);

  logic [POS_W-1:0] pos_q, pos_n;
  logic             prog_trk_q, prog_trk_n;
  logic             erase_trk_q, erase_trk_n;
  logic             cfi_q, cfi_n;
  logic             recording;
  logic             hit_query;
  logic             hit_erase;

  assign recording = (pos_q < POS_LIMIT);
  assign hit_query = fire & recording & (pos_q == '0) & step.query;
  assign hit_prog  = fire & recording & (pos_q == POS_PROG) & prog_trk_q;
  assign hit_erase = fire & recording & (pos_q == POS_ERASE) & erase_trk_q;
  assign hit_sector = hit_erase & step.sel_sector;
  assign hit_chip   = hit_erase & step.sel_chip;

  always_comb begin
    pos_n       = pos_q;
    prog_trk_n  = prog_trk_q;
    erase_trk_n = erase_trk_q;
    cfi_n       = cfi_q;
    if (recording) begin
      pos_n       = pos_q + POS_W'(1);
      prog_trk_n  = prog_trk_q & step.prog_ok;
      erase_trk_n = erase_trk_q & step.erase_ok;
    end
    if (hit_query) begin
      cfi_n = 1'b1;
      pos_n = '0;
    end
    if (hit_prog) pos_n = '0;
    if (!step.unlock) pos_n = '0;
    if (step.leave) begin
      pos_n = '0;
      cfi_n = 1'b0;
    end
    if (pos_n == '0) begin
      prog_trk_n  = 1'b1;
      erase_trk_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= '0;
      prog_trk_q  <= 1'b1;
      erase_trk_q <= 1'b1;
      cfi_q       <= 1'b0;
    end else if (fire) begin
      pos_q       <= pos_n;
      prog_trk_q  <= prog_trk_n;
      erase_trk_q <= erase_trk_n;
      cfi_q       <= cfi_n;
    end
  end

  assign pos      = pos_q;
  assign cfi_mode = cfi_q;

  // R9: position never runs past the recording limit
  a_r9_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LIMIT);

  // R3: exit data always leaves query mode
  a_r3_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && step.leave) |=> !cfi_q);

  // R2: query pattern as first write enters query mode
  a_r2_query_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pos_q == '0 && step.query) |=> cfi_q);

  // R10: state holds without an enabled write
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(cfi_q) && $stable(pos_q)));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int MAP_AW      = 25,
  parameter int SECTOR_LOG2 = 17,
  parameter int HIST_DEPTH  = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          save_en,
  input  logic                          wr_en,
  input  logic [11:0]                   wr_addr,
  input  logic [7:0]                    wr_data,
  input  logic [MAP_AW-1:0]             map_addr,
  input  logic [7:0]                    cur_byte,
  output logic                          prog_pulse,
  output logic                          prog_refused,
  output logic                          sect_erase_pulse,
  output logic                          chip_erase_pulse,
  output logic [MAP_AW-SECTOR_LOG2-1:0] sector_idx,
  output logic [MAP_AW-1:0]             op_addr,
  output logic [7:0]                    op_data,
  output logic                          cfi_mode
);
  localparam int POS_W  = $clog2(HIST_DEPTH + 1);
  localparam int SECT_W = MAP_AW - SECTOR_LOG2;

  logic             rst_sync_n;
  logic             fire;
  step_t            step;
  logic [POS_W-1:0] pos;
  logic             hit_prog, hit_sector, hit_chip;
  logic             blank;
  logic             any_hit;

  logic              prog_q, refused_q, sect_q, chip_q;
  logic              prog_n, refused_n, sect_n, chip_n;
  logic [SECT_W-1:0] sidx_q;
  logic [MAP_AW-1:0] oaddr_q;
  logic [7:0]        odata_q;

  flash_cmd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign fire = wr_en & save_en;

  flash_cmd_match #(.POS_W(POS_W)) u_match (
    .addr (wr_addr),
    .data (wr_data),
    .pos  (pos),
    .step (step)
  );

  flash_cmd_seq #(.HIST_DEPTH(HIST_DEPTH), .POS_W(POS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fire       (fire),
    .step       (step),
    .pos        (pos),
    .hit_prog   (hit_prog),
    .hit_sector (hit_sector),
    .hit_chip   (hit_chip),
    .cfi_mode   (cfi_mode)
  );

  assign blank   = (cur_byte == BLANK_BYTE);
  assign any_hit = hit_prog | hit_sector | hit_chip;

  always_comb begin
    prog_n    = hit_prog & blank;
    refused_n = hit_prog & ~blank;
    sect_n    = hit_sector;
    chip_n    = hit_chip;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prog_q    <= 1'b0;
      refused_q <= 1'b0;
      sect_q    <= 1'b0;
      chip_q    <= 1'b0;
    end else begin
      prog_q    <= prog_n;
      refused_q <= refused_n;
      sect_q    <= sect_n;
      chip_q    <= chip_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sidx_q  <= '0;
      oaddr_q <= '0;
      odata_q <= '0;
    end else if (any_hit) begin
      sidx_q  <= map_addr[MAP_AW-1:SECTOR_LOG2];
      oaddr_q <= map_addr;
      odata_q <= wr_data;
    end
  end

  assign prog_pulse       = prog_q;
  assign prog_refused     = refused_q;
  assign sect_erase_pulse = sect_q;
  assign chip_erase_pulse = chip_q;
  assign sector_idx       = sidx_q;
  assign op_addr          = oaddr_q;
  assign op_data          = odata_q;

  // R11: at most one outcome per cycle
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({prog_q, refused_q, sect_q, chip_q}));

  // R10: no outcome follows a cycle without an enabled write
  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && save_en) |=> !(prog_q || refused_q || sect_q || chip_q));

  // R5: programming only on a blank byte
  a_r5_blank_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prog_q |-> ($past(cur_byte) == BLANK_BYTE));

  // R6: reported sector matches the mapped address of the deciding write
  a_r6_sector_idx: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sect_q |-> (sidx_q == $past(map_addr[MAP_AW-1:SECTOR_LOG2])));
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  logic        clk;
  logic        rst_n;
  logic        save_en;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic [24:0] map_addr;
  logic [7:0]  cur_byte;
  logic        prog_pulse, prog_refused, sect_erase_pulse, chip_erase_pulse;
  logic [7:0]  sector_idx;
  logic [24:0] op_addr;
  logic [7:0]  op_data;
  logic        cfi_mode;

  int tests  = 0;
  int fails  = 0;
  bit done   = 0;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .save_en(save_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .map_addr(map_addr),
    .cur_byte(cur_byte), .prog_pulse(prog_pulse), .prog_refused(prog_refused),
    .sect_erase_pulse(sect_erase_pulse), .chip_erase_pulse(chip_erase_pulse),
    .sector_idx(sector_idx), .op_addr(op_addr), .op_data(op_data),
    .cfi_mode(cfi_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one write for one clock; returns at the following negedge,
  // where registered outputs reflect that write.
  task automatic wr(input logic [11:0] a, input logic [7:0] d,
                    input logic [24:0] m, input logic [7:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; map_addr = m; cur_byte = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic logic [3:0] pulses();
    return {prog_pulse, prog_refused, sect_erase_pulse, chip_erase_pulse};
  endfunction

  task automatic erase_prefix();
    wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    wr(12'h555, 8'h55, 25'd0, 8'hFF);
    wr(12'hAAA, 8'h80, 25'd0, 8'hFF);
    wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    wr(12'h555, 8'h55, 25'd0, 8'hFF);
  endtask

  task automatic prog_prefix();
    wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    wr(12'h555, 8'h55, 25'd0, 8'hFF);
    wr(12'hAAA, 8'hA0, 25'd0, 8'hFF);
  endtask

  task automatic clear_seq();
    wr(12'hAAA, 8'hF0, 25'd0, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; save_en = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; map_addr = '0; cur_byte = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset cfi", cfi_mode, 0);
    chk("R1 reset pulses", pulses(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release cfi", cfi_mode, 0);
    chk("R1 after release pulses", pulses(), 0);

    // R2 sweep of first-write data at 0xAAA
    for (int d = 0; d < 256; d++) begin
      clear_seq();
      wr(12'hAAA, 8'(d), 25'd0, 8'hFF);
      chk("R2 query entry sweep", cfi_mode, (d == 8'h98) ? 1 : 0);
      chk("R2 no pulse on query", pulses(), 0);
    end
    clear_seq();
    wr(12'h555, 8'h98, 25'd0, 8'hFF);
    chk("R2 query at 0x555 ignored", cfi_mode, 0);

    // R3 query mode persists, then 0xF0 anywhere clears it
    clear_seq();
    wr(12'hAAA, 8'h98, 25'd0, 8'hFF);
    wr(12'h123, 8'h11, 25'd0, 8'hFF);
    wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    chk("R3 query persists", cfi_mode, 1);
    wr(12'h7F0, 8'hF0, 25'd0, 8'hFF);
    chk("R3 exit clears query", cfi_mode, 0);

    // R1 reset clears query mode
    wr(12'hAAA, 8'h98, 25'd0, 8'hFF);
    chk("R1 query set before reset", cfi_mode, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears query", cfi_mode, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4/R5 sweep over every current byte value
    for (int c = 0; c < 256; c++) begin
      logic [7:0]  d;
      logic [24:0] m;
      d = 8'(c) ^ 8'h5A;
      m = 25'(c) * 25'd4099 + 25'd7;
      clear_seq();
      prog_prefix();
      chk("R4 no early pulse", pulses(), 0);
      wr(12'h3C3, d, m, 8'(c));
      if (c == 255) begin
        chk("R4 program pulse", pulses(), 4'b1000);
        chk("R4 program addr", op_addr, m);
        chk("R4 program data", op_data, d);
      end else begin
        chk("R5 refused pulse", pulses(), 4'b0100);
      end
      idle();
      chk("R11 pulse one cycle", pulses(), 0);
    end

    // R4 sequence restarts after a program: immediate second program works
    clear_seq();
    prog_prefix();
    wr(12'hAAA, 8'h12, 25'd100, 8'hFF);
    chk("R4 first program", pulses(), 4'b1000);
    prog_prefix();
    wr(12'h555, 8'h34, 25'd200, 8'hFF);
    chk("R4 restart second program", pulses(), 4'b1000);
    chk("R4 restart data", op_data, 8'h34);

    // R6/R7 sweep over every sixth-write data value
    for (int d = 0; d < 256; d++) begin
      logic [24:0] m;
      m = (25'(d) << 17) | 25'h0_1234;
      clear_seq();
      erase_prefix();
      chk("R6 no early pulse", pulses(), 0);
      wr(12'hAAA, 8'(d), m, 8'h00);
      if (d == 8'h30) begin
        chk("R6 sector erase pulse", pulses(), 4'b0010);
        chk("R6 sector index", sector_idx, 8'h30);
      end else if (d == 8'h10) begin
        chk("R7 chip erase pulse", pulses(), 4'b0001);
      end else begin
        chk("R7 other selector no erase", pulses(), 0);
      end
      idle();
      chk("R11 erase pulse one cycle", pulses(), 0);
    end

    // R6 sector index from a different mapped address
    clear_seq();
    erase_prefix();
    wr(12'h555, 8'h30, 25'h1FE_0000 | 25'h1_FFFF, 8'hFF);
    chk("R6 top sector index", sector_idx, 8'hFF);

    // R8 foreign address aborts a sequence
    clear_seq();
    wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    wr(12'h555, 8'h55, 25'd0, 8'hFF);
    wr(12'h100, 8'h00, 25'd0, 8'hFF);
    wr(12'hAAA, 8'hA0, 25'd0, 8'hFF);
    wr(12'hAAA, 8'h77, 25'd0, 8'hFF);
    chk("R8 aborted program", pulses(), 0);
    clear_seq();
    wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    wr(12'h555, 8'h55, 25'd0, 8'hFF);
    wr(12'hAAA, 8'h80, 25'd0, 8'hFF);
    wr(12'hABA, 8'hAA, 25'd0, 8'hFF);
    wr(12'h555, 8'h55, 25'd0, 8'hFF);
    wr(12'hAAA, 8'h10, 25'd0, 8'hFF);
    chk("R8 aborted chip erase", pulses(), 0);
    clear_seq();
    prog_prefix();
    wr(12'h100, 8'h5C, 25'd9, 8'hFF);
    chk("R8 fourth write address free", pulses(), 4'b1000);

    // R3 exit data mid-sequence aborts it
    clear_seq();
    wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    wr(12'h555, 8'h55, 25'd0, 8'hFF);
    wr(12'h555, 8'hF0, 25'd0, 8'hFF);
    wr(12'hAAA, 8'hA0, 25'd0, 8'hFF);
    wr(12'hAAA, 8'h01, 25'd0, 8'hFF);
    chk("R3 exit aborts sequence", pulses(), 0);

    // R9 saturation: long run of unlock writes never re-arms the first position
    clear_seq();
    for (int i = 0; i < 20; i++) wr(12'hAAA, 8'hAA, 25'd0, 8'hFF);
    wr(12'hAAA, 8'h98, 25'd0, 8'hFF);
    chk("R9 saturated no query entry", cfi_mode, 0);
    chk("R9 saturated no pulse", pulses(), 0);

    // R10 saving disabled ignores writes
    clear_seq();
    save_en = 1'b0;
    wr(12'hAAA, 8'h98, 25'd0, 8'hFF);
    chk("R10 disabled no query", cfi_mode, 0);
    prog_prefix();
    wr(12'hAAA, 8'h42, 25'd0, 8'hFF);
    chk("R10 disabled no program", pulses(), 0);
    save_en = 1'b1;
    wr(12'hAAA, 8'h98, 25'd0, 8'hFF);
    save_en = 1'b0;
    wr(12'hAAA, 8'hF0, 25'd0, 8'hFF);
    chk("R10 disabled exit ignored", cfi_mode, 1);
    save_en = 1'b1;
    clear_seq();
    chk("R3 exit after re-enable", cfi_mode, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule